// File: doc/BRIEF.md
# Block-Ring Sample Writer

This block accepts 32-bit sample words on a valid/ready input and stores each one at the next word address of a shared memory region. The region is a ring of equal-sized blocks (by default eight blocks of 128 KiB, 1 MiB in total). Samples arrive in frames of eight words. A byte counter for the current block drops by one frame's worth (32 bytes) after each complete frame. When that counter runs out, the block is closed and a one-cycle completion event reports the index of the block that just filled, so a host can drain it.

A start pulse arms the writer with a base address, a region size and a requested number of blocks. The region size must equal the ring's block size times its block count. If it does not, or if the requested count is zero, the writer raises an error and stays stopped. While running, the writer counts block completions against the requested total and stops with done raised when the total is reached. The write offset wraps to the start of the region after the last block of the ring. After done or error, the input is refused until the next start.

Top module: `sample_block_writer`

## Requirements
- R1: After reset, word_ready, mem_we, blk_evt, done and err are all low, and they stay so until a start pulse arrives.
- R2: A start pulse with cfg_region_bytes equal to BLOCK_BYTES*NUM_BLKS and a nonzero cfg_num_blocks raises word_ready from the next cycle on. The first accepted word is then written at cfg_base.
- R3: mem_we is high exactly in cycles where word_valid and word_ready are both high. mem_data equals word_data, and mem_addr is cfg_base plus a byte offset that grows by 4 with every accepted word.
- R4: The block's byte counter falls by 32 after each frame of 8 words. When it reaches zero, blk_evt is high for exactly one cycle, the cycle after the last word of the block is accepted. blk_evt_idx then holds the finished block's index, counted from 0 in write order.
- R5: Once the last block of the ring (index NUM_BLKS-1) completes, the next word is written at cfg_base again and the next event carries index 0.
- R6: When the number of completed blocks reaches cfg_num_blocks, done rises in the same cycle as that last event. word_ready is then low, and further valid words cause no write.
- R7: A start pulse with any other region size sets err from the next cycle. word_ready stays low and no write occurs.
- R8: A start pulse with cfg_num_blocks equal to zero sets err in the same way as R7.
- R9: A start pulse while running is ignored: the address sequence continues and the configuration latched at the earlier start still governs when done rises.
- R10: A start pulse from the done or error state begins a new run from cfg_base, with block index 0 and the newly supplied count.
- R11: A cycle with word_valid low neither writes nor advances the address or the frame count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a run |
| cfg_base | input | ADDR_W | Byte address of the region's first word |
| cfg_region_bytes | input | ADDR_W | Region size offered by the host, checked at start |
| cfg_num_blocks | input | CNT_W | Number of blocks to fill before stopping |
| word_valid | input | 1 | Sample word present |
| word_data | input | DATA_W | Sample word |
| word_ready | output | 1 | Writer takes a word this cycle |
| mem_addr | output | ADDR_W | Write byte address |
| mem_data | output | DATA_W | Write data |
| mem_we | output | 1 | Write enable |
| blk_evt | output | 1 | One-cycle block completion event |
| blk_evt_idx | output | IDX_W | Index of the block just completed |
| done | output | 1 | Requested block count reached |
| err | output | 1 | Start refused: bad region size or zero count |

## Verification
The assertions rely on three things about the inputs. cfg_base must stay constant during a run, so that two back-to-back writes differ by exactly one word or land back on the base. A start pulse arriving outside a run must reset the per-block word tally kept by the checker. The block size must be a whole number of frames, which the elaboration checks enforce. The stimulus meets the first two by changing configuration only in start cycles and by pulsing start only while word_valid is low. It uses a reduced ring of four 64-byte blocks, which keeps every wrap and completion within reach in a short run.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

   typedef enum logic [1:0] {
      SBW_IDLE  = 2'd0,
      SBW_RUN   = 2'd1,
      SBW_DONE  = 2'd2,
      SBW_FAULT = 2'd3
   } sbw_state_e;

endpackage

// File: rtl/sbw_ctrl.sv
module sbw_ctrl
   import sbw_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int CNT_W        = 16,
   parameter int REGION_BYTES = 32'h100000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] cfg_region_bytes,
   input  logic [CNT_W-1:0]  cfg_num_blocks,
   input  logic              blk_close,
   output logic              run,
   output logic              launch,
   output logic              done,
   output logic              err
);

   sbw_state_e       state_q;
   logic [CNT_W-1:0] left_q;
   logic             size_ok;
   logic             count_ok;

   assign size_ok  = (cfg_region_bytes == ADDR_W'(REGION_BYTES));
   assign count_ok = (cfg_num_blocks != '0);
   assign launch   = start && (state_q != SBW_RUN) && size_ok && count_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SBW_IDLE;
         left_q  <= '0;
      end else begin
         case (state_q)
            SBW_RUN: begin
               if (blk_close) begin
                  left_q <= left_q - 1'b1;
                  if (left_q == CNT_W'(1)) state_q <= SBW_DONE;
               end
            end
            default: begin
               if (start) begin
                  if (size_ok && count_ok) begin
                     state_q <= SBW_RUN;
                     left_q  <= cfg_num_blocks;
                  end else begin
                     state_q <= SBW_FAULT;
                  end
               end
            end
         endcase
      end
   end

   assign run  = (state_q == SBW_RUN);
   assign done = (state_q == SBW_DONE);
   assign err  = (state_q == SBW_FAULT);

endmodule

// File: rtl/sbw_frame_track.sv
module sbw_frame_track #(
   parameter int FRAME_WORDS = 8,
   parameter int FRAME_BYTES = 32,
   parameter int BLOCK_BYTES = 32'h20000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic accept,
   output logic blk_close
);

   localparam int LEFT_W = $clog2(BLOCK_BYTES + 1);

   logic              frame_end;
   logic [LEFT_W-1:0] left_q;

   generate
      if (FRAME_WORDS == 1) begin : g_single
         assign frame_end = accept;
      end else begin : g_multi
         localparam int FW_W = $clog2(FRAME_WORDS);
         logic [FW_W-1:0] word_q;

         assign frame_end = accept && (word_q == FW_W'(FRAME_WORDS - 1));

         always_ff @(posedge clk) begin
            if (!rst_n || clear)  word_q <= '0;
            else if (frame_end)   word_q <= '0;
            else if (accept)      word_q <= word_q + 1'b1;
         end
      end
   endgenerate

   assign blk_close = frame_end && (left_q == LEFT_W'(FRAME_BYTES));

   always_ff @(posedge clk) begin
      if (!rst_n || clear)  left_q <= LEFT_W'(BLOCK_BYTES);
      else if (blk_close)   left_q <= LEFT_W'(BLOCK_BYTES);
      else if (frame_end)   left_q <= left_q - LEFT_W'(FRAME_BYTES);
   end

endmodule

// File: rtl/sbw_addr_gen.sv
module sbw_addr_gen #(
   parameter int ADDR_W      = 32,
   parameter int BLOCK_BYTES = 32'h20000,
   parameter int NUM_BLKS    = 8,
   parameter int WORD_BYTES  = 4,
   parameter int IDX_W       = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              accept,
   input  logic              blk_close,
   input  logic [ADDR_W-1:0] cfg_base,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [IDX_W-1:0]  blk_idx
);

   localparam int  OFF_W     = $clog2(BLOCK_BYTES);
   localparam bit  BLK_POW2  = ((BLOCK_BYTES & (BLOCK_BYTES - 1)) == 0);

   logic [OFF_W-1:0]  off_q;
   logic [IDX_W-1:0]  idx_q;
   logic [ADDR_W-1:0] ring_off;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         off_q <= '0;
         idx_q <= '0;
      end else if (accept) begin
         if (blk_close) begin
            off_q <= '0;
            idx_q <= (idx_q == IDX_W'(NUM_BLKS - 1)) ? '0 : idx_q + 1'b1;
         end else begin
            off_q <= off_q + OFF_W'(WORD_BYTES);
         end
      end
   end

   generate
      if (BLK_POW2) begin : g_concat
         assign ring_off = ADDR_W'({idx_q, off_q});
      end else begin : g_mult
         assign ring_off = ADDR_W'(idx_q) * ADDR_W'(BLOCK_BYTES) + ADDR_W'(off_q);
      end
   endgenerate

   assign mem_addr = cfg_base + ring_off;
   assign blk_idx  = idx_q;

endmodule

// File: rtl/sample_block_writer.sv
module sample_block_writer #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int CNT_W       = 16,
   parameter int BLOCK_BYTES = 32'h20000,
   parameter int NUM_BLKS    = 8,
   parameter int FRAME_WORDS = 8,
   parameter int WORD_BYTES  = 4,
   localparam int IDX_W      = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [ADDR_W-1:0] cfg_region_bytes,
   input  logic [CNT_W-1:0]  cfg_num_blocks,
   input  logic              word_valid,
   input  logic [DATA_W-1:0] word_data,
   output logic              word_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data,
   output logic              mem_we,
   output logic              blk_evt,
   output logic [IDX_W-1:0]  blk_evt_idx,
   output logic              done,
   output logic              err
);

   localparam int FRAME_BYTES  = FRAME_WORDS * WORD_BYTES;
   localparam int REGION_BYTES = BLOCK_BYTES * NUM_BLKS;

   generate
      if (FRAME_WORDS < 1) begin : g_chk_frame
         $error("FRAME_WORDS must be at least 1");
      end
      if (BLOCK_BYTES % FRAME_BYTES != 0) begin : g_chk_blk
         $error("BLOCK_BYTES must be a whole number of frames");
      end
      if (NUM_BLKS < 1) begin : g_chk_nblk
         $error("NUM_BLKS must be at least 1");
      end
      if ($clog2(REGION_BYTES) >= ADDR_W) begin : g_chk_addr
         $error("ADDR_W too narrow for the region");
      end
      if (DATA_W != 8 * WORD_BYTES) begin : g_chk_word
         $error("DATA_W must equal 8*WORD_BYTES");
      end
   endgenerate

   logic             run;
   logic             launch;
   logic             accept;
   logic             blk_close;
   logic [IDX_W-1:0] blk_idx;

   assign accept     = word_valid && run;
   assign word_ready = run;
   assign mem_we     = accept;
   assign mem_data   = word_data;

   sbw_ctrl #(
      .ADDR_W       (ADDR_W),
      .CNT_W        (CNT_W),
      .REGION_BYTES (REGION_BYTES)
   ) u_ctrl (
      .clk              (clk),
      .rst_n            (rst_n),
      .start            (start),
      .cfg_region_bytes (cfg_region_bytes),
      .cfg_num_blocks   (cfg_num_blocks),
      .blk_close        (blk_close),
      .run              (run),
      .launch           (launch),
      .done             (done),
      .err              (err)
   );

   sbw_frame_track #(
      .FRAME_WORDS (FRAME_WORDS),
      .FRAME_BYTES (FRAME_BYTES),
      .BLOCK_BYTES (BLOCK_BYTES)
   ) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (launch),
      .accept    (accept),
      .blk_close (blk_close)
   );

   sbw_addr_gen #(
      .ADDR_W      (ADDR_W),
      .BLOCK_BYTES (BLOCK_BYTES),
      .NUM_BLKS    (NUM_BLKS),
      .WORD_BYTES  (WORD_BYTES),
      .IDX_W       (IDX_W)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (launch),
      .accept    (accept),
      .blk_close (blk_close),
      .cfg_base  (cfg_base),
      .mem_addr  (mem_addr),
      .blk_idx   (blk_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blk_evt     <= 1'b0;
         blk_evt_idx <= '0;
      end else begin
         blk_evt <= blk_close;
         if (blk_close) blk_evt_idx <= blk_idx;
      end
   end

endmodule

// File: rtl/sbw_checker.sv
module sbw_checker #(
   parameter int ADDR_W      = 32,
   parameter int BLOCK_BYTES = 32'h20000,
   parameter int WORD_BYTES  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [ADDR_W-1:0] cfg_base,
   input logic              word_valid,
   input logic              word_ready,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              blk_evt,
   input logic              done,
   input logic              err
);

   localparam int WPB = BLOCK_BYTES / WORD_BYTES;

   logic [31:0] words_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                     words_q <= '0;
      else if (start && !word_ready)  words_q <= '0;
      else if (blk_evt)               words_q <= mem_we ? 32'd1 : 32'd0;
      else if (mem_we)                words_q <= words_q + 32'd1;
   end

   // R3: writes only on a handshake
   a_r3_we_handshake: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (word_valid && word_ready));

   // R3, R5: consecutive writes step by one word or return to the base
   a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |->
         ((mem_addr == $past(mem_addr) + ADDR_W'(WORD_BYTES)) || (mem_addr == cfg_base)));

   // R4: event lasts one cycle
   a_r4_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
      blk_evt |=> !blk_evt);

   // R4: each event closes exactly one block of words
   a_r4_block_len: assert property (@(posedge clk) disable iff (!rst_n)
      blk_evt |-> (words_q == 32'(WPB)));

   // R6: done appears together with the final event
   a_r6_done_with_evt: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> blk_evt);

   // R6: input refused once done
   a_r6_done_refuses: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!word_ready && !mem_we));

   // R7: input refused on error
   a_r7_err_refuses: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!word_ready && !mem_we));

   // R1: at most one of running, done, error
   a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, err, word_ready}));

endmodule

bind sample_block_writer sbw_checker #(
   .ADDR_W      (ADDR_W),
   .BLOCK_BYTES (BLOCK_BYTES),
   .WORD_BYTES  (WORD_BYTES)
) u_sbw_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .cfg_base   (cfg_base),
   .word_valid (word_valid),
   .word_ready (word_ready),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .blk_evt    (blk_evt),
   .done       (done),
   .err        (err)
);

// File: tb/sample_block_writer_test.sv
module sample_block_writer_test;

   localparam int BLK   = 64;
   localparam int NBLK  = 4;
   localparam int WPB   = BLK / 4;
   localparam int RGN   = BLK * NBLK;
   localparam int NVEC  = 6;

   // stimulus / expectation table: region size, block count, base, expect error
   localparam int          V_REGION [NVEC] = '{256, 512, 256, 256, 256, 128};
   localparam int          V_COUNT  [NVEC] = '{1,   2,   3,   0,   6,   2};
   localparam logic [31:0] V_BASE   [NVEC] = '{32'h8000_0000, 32'h8000_0000, 32'h0000_1000,
                                               32'h8000_0000, 32'h4000_0100, 32'h8000_0000};
   localparam bit          V_ERR    [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] cfg_base = '0;
   logic [31:0] cfg_region_bytes = '0;
   logic [7:0]  cfg_num_blocks = '0;
   logic        word_valid = 1'b0;
   logic [31:0] word_data = '0;
   logic        word_ready;
   logic [31:0] mem_addr;
   logic [31:0] mem_data;
   logic        mem_we;
   logic        blk_evt;
   logic [1:0]  blk_evt_idx;
   logic        done;
   logic        err;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   sample_block_writer #(
      .ADDR_W (32), .DATA_W (32), .CNT_W (8),
      .BLOCK_BYTES (BLK), .NUM_BLKS (NBLK), .FRAME_WORDS (8), .WORD_BYTES (4)
   ) uut (
      .clk (clk), .rst_n (rst_n), .start (start), .cfg_base (cfg_base),
      .cfg_region_bytes (cfg_region_bytes), .cfg_num_blocks (cfg_num_blocks),
      .word_valid (word_valid), .word_data (word_data), .word_ready (word_ready),
      .mem_addr (mem_addr), .mem_data (mem_data), .mem_we (mem_we),
      .blk_evt (blk_evt), .blk_evt_idx (blk_evt_idx), .done (done), .err (err)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic pulse_start(input logic [31:0] base, input int region, input int count);
      @(negedge clk);
      cfg_base = base; cfg_region_bytes = region; cfg_num_blocks = 8'(count);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // streams 'total' words from word index k0, with a gap every fifth cycle
   task automatic stream(input logic [31:0] base, input int k0, input int total, input int tag);
      int  k = k0;
      int  g = 0;
      bit  exp_evt = 1'b0;
      int  exp_idx = 0;
      logic [31:0] d;
      while (k < k0 + total) begin
         chk((blk_evt == exp_evt) && (!exp_evt || blk_evt_idx == 2'(exp_idx)),
             "R4 event/index", {blk_evt, 29'd0, blk_evt_idx}, {exp_evt, 29'd0, 2'(exp_idx)});
         exp_evt = 1'b0;
         if ((g % 5) == 3) begin
            word_valid = 1'b0;
            #1 chk(mem_we == 1'b0, "R11 no write on idle", {31'd0, mem_we}, 32'd0);
         end else begin
            d = 32'hA500_0000 ^ (32'(k) * 32'h0101_0101) ^ 32'(tag);
            word_valid = 1'b1; word_data = d;
            #1;
            chk(mem_we && word_ready, "R3 write strobe", {31'd0, mem_we}, 32'd1);
            chk(mem_addr == base + 32'((k * 4) % RGN), "R3/R5 address", mem_addr, base + 32'((k * 4) % RGN));
            chk(mem_data == d, "R3 data", mem_data, d);
            if (((k + 1) % WPB) == 0) begin
               exp_evt = 1'b1;
               exp_idx = (k / WPB) % NBLK;
            end
            k++;
         end
         g++;
         @(negedge clk);
      end
      word_valid = 1'b0;
      chk((blk_evt == exp_evt) && (!exp_evt || blk_evt_idx == 2'(exp_idx)),
          "R4 final event", {blk_evt, 29'd0, blk_evt_idx}, {exp_evt, 29'd0, 2'(exp_idx)});
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog R6 run never ended act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 chk(!word_ready && !mem_we && !blk_evt && !done && !err, "R1 reset state",
             {27'd0, word_ready, mem_we, blk_evt, done, err}, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      word_valid = 1'b1;
      #1 chk(!word_ready && !mem_we && !done && !err, "R1 idle without start",
             {28'd0, word_ready, mem_we, done, err}, 32'd0);
      word_valid = 1'b0;

      // table walk: consecutive runs also exercise restart from done/error (R10)
      for (int v = 0; v < NVEC; v++) begin
         pulse_start(V_BASE[v], V_REGION[v], V_COUNT[v]);
         #1;
         if (V_ERR[v]) begin
            chk(err && !word_ready && !done, V_COUNT[v] == 0 ? "R8 zero count error" : "R7 size error",
                {29'd0, err, word_ready, done}, 32'd4);
            word_valid = 1'b1;
            #1 chk(!mem_we, "R7 no write in error", {31'd0, mem_we}, 32'd0);
            @(negedge clk);
            word_valid = 1'b0;
         end else begin
            chk(word_ready && !err && !done, "R2/R10 start accepted",
                {29'd0, word_ready, err, done}, 32'd4);
            stream(V_BASE[v], 0, V_COUNT[v] * WPB, v);
            #1 chk(done && !word_ready, "R6 done after count", {30'd0, done, word_ready}, 32'd2);
            word_valid = 1'b1;
            #1 chk(!mem_we, "R6 no write after done", {31'd0, mem_we}, 32'd0);
            @(negedge clk);
            word_valid = 1'b0;
         end
      end

      // R9: start while running is ignored
      pulse_start(32'h8000_0000, RGN, 1);
      stream(32'h8000_0000, 0, 5, 9);
      cfg_base = 32'h8000_0000; cfg_num_blocks = 8'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      #1 chk(word_ready && !err, "R9 still running", {30'd0, word_ready, err}, 32'd2);
      stream(32'h8000_0000, 5, WPB - 5, 9);
      #1 chk(done && !word_ready, "R9 original count kept", {30'd0, done, word_ready}, 32'd2);

      // R1: reset in the middle of a run
      pulse_start(32'h8000_0000, RGN, 2);
      stream(32'h8000_0000, 0, 3, 11);
      rst_n = 1'b0;
      @(negedge clk);
      #1 chk(!word_ready && !done && !err && !blk_evt, "R1 mid-run reset",
             {28'd0, word_ready, done, err, blk_evt}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      #1 chk(!word_ready, "R1 idle after reset", {31'd0, word_ready}, 32'd0);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule